// File: doc/BRIEF.md
# Dithered Split-Cycle PWM Generator

This block produces one pulse-width-modulated output from an 8-bit duty value. Each 256-clock frame is cut into equal sub-cycles, two of 128 clocks or four of 64 clocks. The duty value is decoded into two parts. The base width is the upper bits. The spread count is the lower bits, one bit with two sub-cycles and two bits with four. Every sub-cycle starts high and stays high for the base width. The first "spread count" sub-cycles each get one extra high clock. Over a frame the output is high for exactly as many clocks as the duty value. The output ripple, however, runs at two or four times the frame rate.

The duty value and the split mode are plain control pins. They are captured once per frame, on the last clock of the frame, so software may rewrite them at any time and no sub-cycle is ever cut short. The enable pin gates the registered output. A free-running position counter restarts from zero when reset is released.

Top module: `split_pwm`

## Requirements
- R1: A position counter advances by one every clock from 0 after reset and wraps from 255 to 0, giving a frame of 256 clocks.
- R2: With `mode_i` = 1, the frame is two sub-cycles of 128 clocks (sub-cycle index = position bit 7). The base width is `duty_i[7:1]` and the spread count is `duty_i[0]`.
- R3: With `mode_i` = 0, the frame is four sub-cycles of 64 clocks (sub-cycle index = position bits 7:6). The base width is `duty_i[7:2]` and the spread count is `duty_i[1:0]`.
- R4: Sub-cycle i is high from its first clock for base+1 clocks if i < spread, otherwise for base clocks, and low for the rest. A base of 0 with i >= spread gives an all-low sub-cycle. The high count over a frame equals the duty value.
- R5: The duty value and mode are captured on the clock where the position is 255. A change during a frame has no effect until the next frame.
- R6: When `en_i` is sampled 0 on a clock edge, `pwm_o` is 0 after that edge. The position counter keeps running while disabled.
- R7: A captured duty of 0 keeps the output low. A captured duty of 255 keeps it high on every position except 255, in either mode.
- R8: During reset `pwm_o` is 0 and the captured duty is 0, so the first frame after reset is all low, whatever `duty_i` is.
- R9: The output is registered. After the k-th clock edge following reset release, `pwm_o` shows position k-1 (mod 256).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the PWM count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | 8 | Duty value, captured at frame end |
| mode_i | input | 1 | 1: two sub-cycles, 0: four sub-cycles |
| en_i | input | 1 | Output enable |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The hardest case to reach is a duty or mode change that lands inside a frame. The capture depends on where the hidden position counter stands. The stimulus counts clock edges from reset release, so it always knows the position. It rewrites both duty and mode at position 100 of a frame. It then checks that this frame keeps the old shape and that the next frame, sampled with no gap, takes the new one. Enable drops and returns at known positions to check the one-clock gating lag.

// File: rtl/split_pwm_pkg.sv
package split_pwm_pkg;
  localparam int PWM_W = 8;

  typedef enum logic {
    SPLIT_FOUR = 1'b0,
    SPLIT_TWO  = 1'b1
  } split_e;
endpackage

// File: rtl/split_pwm_ticker.sv
module split_pwm_ticker #(
  parameter int W = split_pwm_pkg::PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] pos_o,
  output logic         last_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};

  logic [W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == POS_MAX);
endmodule

// File: rtl/split_pwm_hold.sv
module split_pwm_hold #(
  parameter int W = split_pwm_pkg::PWM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [W-1:0]          duty_i,
  input  split_pwm_pkg::split_e mode_i,
  output logic [W-1:0]          duty_o,
  output split_pwm_pkg::split_e mode_o
);
  logic [W-1:0]          duty_q;
  split_pwm_pkg::split_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      mode_q <= split_pwm_pkg::SPLIT_FOUR;
    end else if (load_i) begin
      duty_q <= duty_i;
      mode_q <= mode_i;
    end
  end

  assign duty_o = duty_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/split_pwm_shaper.sv
module split_pwm_shaper #(
  parameter int W = split_pwm_pkg::PWM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          pos_i,
  input  logic [W-1:0]          duty_i,
  input  split_pwm_pkg::split_e mode_i,
  input  logic                  en_i,
  output logic                  pwm_o
);
  localparam int NVAR = 2;

  // hi_vec[v] is the level for a split into 2**(v+1) sub-cycles
  logic [NVAR-1:0] hi_vec;

  for (genvar g = 1; g <= NVAR; g++) begin : g_split
    localparam int SB = g;
    localparam int PB = W - SB;
    logic [SB-1:0] idx;
    logic [PB-1:0] offs;
    logic [PB-1:0] base;
    logic [SB-1:0] spread;
    logic [PB:0]   width;

    assign idx    = pos_i[W-1:PB];
    assign offs   = pos_i[PB-1:0];
    assign base   = duty_i[W-1:SB];
    assign spread = duty_i[SB-1:0];
    assign width  = {1'b0, base} + {{PB{1'b0}}, (idx < spread)};
    assign hi_vec[g-1] = ({1'b0, offs} < width);
  end

  logic level;
  always_comb begin
    case (mode_i)
      split_pwm_pkg::SPLIT_TWO: level = hi_vec[0];
      default:                  level = hi_vec[1];
    endcase
  end

  logic pwm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= en_i & level;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/split_pwm.sv
module split_pwm #(
  parameter int W = split_pwm_pkg::PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_i,
  input  logic         mode_i,
  input  logic         en_i,
  output logic         pwm_o
);
  logic [W-1:0]          pos_w;
  logic                  last_w;
  logic [W-1:0]          duty_q_w;
  split_pwm_pkg::split_e mode_q_w;
  split_pwm_pkg::split_e mode_in_w;

  assign mode_in_w = split_pwm_pkg::split_e'(mode_i);

  split_pwm_ticker #(.W(W)) u_ticker (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos_o  (pos_w),
    .last_o (last_w)
  );

  split_pwm_hold #(.W(W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (last_w),
    .duty_i (duty_i),
    .mode_i (mode_in_w),
    .duty_o (duty_q_w),
    .mode_o (mode_q_w)
  );

  split_pwm_shaper #(.W(W)) u_shaper (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos_i  (pos_w),
    .duty_i (duty_q_w),
    .mode_i (mode_q_w),
    .en_i   (en_i),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/split_pwm_chk.sv
module split_pwm_chk #(
  parameter int W = split_pwm_pkg::PWM_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         pwm_o,
  input logic [W-1:0] pos,
  input logic [W-1:0] duty_q
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pos == $past(pos) + 1'b1);

  a_r5_capture_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> $past(pos) == ALL1);

  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> !pwm_o);

  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(duty_q) == '0 |-> !pwm_o);

  a_r7_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty_q) == ALL1 && $past(en_i) && $past(pos) != ALL1) |-> pwm_o);
endmodule

bind split_pwm split_pwm_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .pwm_o  (pwm_o),
  .pos    (pos_w),
  .duty_q (duty_q_w)
);

// File: tb/split_pwm_tb.sv
module split_pwm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty_i = 8'h00;
  logic       mode_i = 1'b0;
  logic       en_i = 1'b0;
  logic       pwm_o;

  int tests = 0;
  int fails = 0;
  int edges = 0;

  always #10 clk = ~clk;

  split_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i),
    .mode_i(mode_i), .en_i(en_i), .pwm_o(pwm_o)
  );

  // {duty, mode, frame high count, first sub-cycle high width}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 1'b1, 9'd0,   8'd0},
    {8'hFF, 1'b1, 9'd255, 8'd128},
    {8'hFF, 1'b0, 9'd255, 8'd64},
    {8'h01, 1'b1, 9'd1,   8'd1},
    {8'h01, 1'b0, 9'd1,   8'd1},
    {8'h03, 1'b0, 9'd3,   8'd1},
    {8'h80, 1'b1, 9'd128, 8'd64},
    {8'h80, 1'b0, 9'd128, 8'd32},
    {8'h6B, 1'b1, 9'd107, 8'd54},
    {8'h6B, 1'b0, 9'd107, 8'd27},
    {8'hFE, 1'b0, 9'd254, 8'd64},
    {8'h02, 1'b1, 9'd2,   8'd1}
  };

  function automatic logic model(input logic [7:0] d, input logic m, input int c);
    int sublen, base, spread, i, p, w;
    sublen = m ? 128 : 64;
    base   = m ? (d >> 1) : (d >> 2);
    spread = m ? (d & 1) : (d & 3);
    i = c / sublen;
    p = c % sublen;
    w = base + ((i < spread) ? 1 : 0);
    return (p < w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    edges++;
  endtask

  task automatic sample_frame(input logic [7:0] d, input logic m, input logic e, input bit midchg,
                              output int nbad, output int badc, output int total, output int sub0);
    nbad = 0; badc = -1; total = 0; sub0 = 0;
    for (int k = 0; k < 256; k++) begin
      int c;
      logic exp;
      step();
      c = (edges - 1) % 256;
      exp = e & model(d, m, c);
      if (pwm_o !== exp) begin
        if (nbad == 0) badc = c;
        nbad++;
      end
      total += int'(pwm_o);
      if (c < (m ? 128 : 64)) sub0 += int'(pwm_o);
      if (midchg && k == 100) begin
        duty_i = ~d;
        mode_i = ~m;
      end
    end
  endtask

  task automatic frame_check(input logic [7:0] d, input logic m, input logic e, input bit midchg,
                             output int nbad, output int badc, output int total, output int sub0);
    duty_i = d; mode_i = m; en_i = e;
    do step(); while (edges % 256 != 0);
    sample_frame(d, m, e, midchg, nbad, badc, total, sub0);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int nbad, badc, total, sub0;

    // R8: reset holds output low
    duty_i = 8'hFF; mode_i = 1'b1; en_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(pwm_o === 1'b0, "R8", "pwm during reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    edges = 0;

    // R8/R9: first frame low although duty is nonzero
    duty_i = 8'hC8;
    sample_frame(8'h00, 1'b1, 1'b1, 1'b0, nbad, badc, total, sub0);
    chk(total == 0, "R8", "first frame high count", total, 0);
    // R9/R5: next frame uses value captured at position 255, one clock latency
    sample_frame(8'hC8, 1'b1, 1'b1, 1'b0, nbad, badc, total, sub0);
    chk(nbad == 0, "R9", "first bad position after capture", badc, -1);

    // Table walk: R2/R3 decode, R4 widths, R7 extremes
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic m;
      int etot, esub;
      d = VEC[v][25:18];
      m = VEC[v][17];
      etot = int'(VEC[v][16:8]);
      esub = int'(VEC[v][7:0]);
      frame_check(d, m, 1'b1, 1'b0, nbad, badc, total, sub0);
      chk(nbad == 0, m ? "R2" : "R3", $sformatf("shape duty %0d first bad position", d), badc, -1);
      chk(total == etot, "R4", $sformatf("frame high count duty %0d", d), total, etot);
      chk(sub0 == esub, "R4", $sformatf("sub-cycle 0 width duty %0d", d), sub0, esub);
      if (d == 8'hFF || d == 8'h00)
        chk(nbad == 0, "R7", $sformatf("extreme duty %0d shape", d), nbad, 0);
    end

    // R5: mid-frame rewrite of duty and mode is deferred one frame
    frame_check(8'h35, 1'b0, 1'b1, 1'b1, nbad, badc, total, sub0);
    chk(nbad == 0, "R5", "old value kept after mid-frame write, bad position", badc, -1);
    sample_frame(8'hCA, 1'b1, 1'b1, 1'b0, nbad, badc, total, sub0);
    chk(nbad == 0, "R5", "new value used in next frame, bad position", badc, -1);

    // R6: disabled frame is all low
    frame_check(8'h80, 1'b1, 1'b0, 1'b0, nbad, badc, total, sub0);
    chk(total == 0, "R6", "disabled frame high count", total, 0);

    // R6: enable toggled mid-frame, one-clock gating lag, counter not stalled
    duty_i = 8'h80; mode_i = 1'b1; en_i = 1'b1;
    do step(); while (edges % 256 != 0);
    nbad = 0;
    for (int k = 0; k < 80; k++) begin
      logic en_used;
      logic exp;
      en_used = en_i;
      step();
      exp = en_used & model(8'h80, 1'b1, (edges - 1) % 256);
      if (pwm_o !== exp) nbad++;
      if (k == 10) en_i = 1'b0;
      if (k == 30) en_i = 1'b1;
    end
    chk(nbad == 0, "R6", "mismatches around enable toggles", nbad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule